// File: doc/BRIEF.md
# Run-Time Programmable Serial CRC Engine

This block computes a cyclic redundancy checksum whose width (5 to 16 bits) and generator taps are chosen by software at run time. Message words are written into an eight-entry queue. Once the run bit is set, a serial shifter pulls the words from the queue one at a time and feeds them most significant bit first into a linear feedback shift register. It consumes two message bits on every clock.

Software seeds the accumulator register before a run. When the queue has drained, it reads the checksum back from the same register. A long message can be handled in pieces: software reads the accumulator, stores it, and writes it back later to resume. To finish a checksum, software appends zero bits by writing zero words.

Top module: `crc_stream_engine`

## Requirements
- R1: After reset the control word reads 16'h0040, and both the tap register and the accumulator read zero.
- R2: There are four registers, selected by address. Address 0 is control: bits [3:0] hold the CRC length minus one, bit 4 is the run bit, bit 5 is the queue-full flag (read only) and bit 6 is the queue-empty flag (read only). Address 1 holds the taps. Address 2 is the accumulator. Writing address 3 pushes a message word, and reading address 3 returns zero.
- R3: Each message bit advances the accumulator one step. Take f = acc[len-1] XOR bit. The accumulator is shifted left and masked to len bits, and if f is 1 it is then XORed with the taps masked to len bits.
- R4: With a length of 8 or less, each queued word supplies only its low byte (8 bits). With a longer length, each word supplies all 16 bits. In both cases bits are taken most significant first.
- R5: The queue holds 8 words. The full flag is set at 8 words, and a push while the queue is full is dropped.
- R6: The empty flag is set exactly when every queued word has been consumed, and any accepted push clears it.
- R7: The engine consumes two message bits per clock. After run is set, eight 16-bit words drain in exactly 64 clocks.
- R8: A write to the accumulator takes effect only while run is clear. A value read back and rewritten later continues the checksum as if the message had never been split.
- R9: While run is clear, no shifting takes place: the accumulator holds its value and queued words stay queued.
- R10: A push and the consumption of the last bits of the head word can fall in the same clock. When they do, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 2 | Write register select |
| wdata | input | 16 | Write data |
| raddr | input | 2 | Read register select |
| rdata | output | 16 | Read data (combinational) |

## Verification
A push into the queue can land in the same clock in which the shifter finishes the head word and pops it. The count must then stay level, with the new word kept and the old one released. To provoke this, the bench sets the run bit first and then streams words in while the shifter drains. Bytes arrive at a rate that keeps the queue near full, and random gaps shift the writes against the pop edges. Each run is judged by comparing the final accumulator with a bench-computed checksum over every accepted word, and by checking that the queue reports empty afterwards.

// File: rtl/crc_stream_engine.sv
module crc_stream_engine #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    waddr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    raddr,
  output logic [DW-1:0] rdata
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = $clog2(DW);
  localparam int HALF = DW / 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_TAPS = 2'd1, A_WORK = 2'd2, A_DATA = 2'd3;

  logic [LW-1:0] len_m1, bitpos, top, hi;
  logic          go;
  logic [DW-1:0] taps, work, mask, head, step1, step2;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   count;
  logic          full, empty, push, pop, shifting;

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] c, input logic b,
                                               input logic [LW-1:0] l, input logic [DW-1:0] t,
                                               input logic [DW-1:0] m);
    logic [DW-1:0] n;
    n = (c << 1) & m;
    if (c[l] ^ b) n = n ^ (t & m);
    return n;
  endfunction

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign push     = wr_en && (waddr == A_DATA) && !full;
  assign shifting = go && !empty;
  assign top      = (len_m1 < LW'(HALF)) ? LW'(HALF-1) : LW'(DW-1);
  assign pop      = shifting && (bitpos == top - LW'(1));
  assign mask     = {DW{1'b1}} >> (LW'(DW-1) - len_m1);
  assign head     = mem[rd_ptr];
  assign hi       = top - bitpos;
  assign step1    = lfsr_step(work,  head[hi],         len_m1, taps, mask);
  assign step2    = lfsr_step(step1, head[hi - LW'(1)], len_m1, taps, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1 <= '0;
      go     <= 1'b0;
      taps   <= '0;
      work   <= '0;
    end else begin
      if (wr_en && waddr == A_CTRL) begin
        len_m1 <= wdata[LW-1:0];
        go     <= wdata[LW];
      end
      if (wr_en && waddr == A_TAPS) taps <= wdata;
      if (wr_en && waddr == A_WORK && !go) work <= wdata;
      else if (shifting) work <= step2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      bitpos <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop) begin
        rd_ptr <= rd_ptr + AW'(1);
        bitpos <= '0;
      end else if (shifting) begin
        bitpos <= bitpos + LW'(2);
      end
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_comb begin
    case (raddr)
      A_CTRL:  rdata = DW'({empty, full, go, len_m1});
      A_TAPS:  rdata = taps;
      A_WORK:  rdata = work;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_stream_engine_sva.sv
module crc_stream_engine_sva #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       go,
  input logic [$clog2(DEPTH):0]     count,
  input logic [DW-1:0]              work,
  input logic                       wr_en,
  input logic [1:0]                 waddr,
  input logic                       push,
  input logic                       pop
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop) |=> (count == CW'(DEPTH)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !(wr_en && waddr == 2'd2)) |=> $stable(work));

  assert_work_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count == '0 && wr_en && waddr == 2'd2) |=> $stable(work));

  assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

  assert_push_clears_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && push) |=> (count != '0));
endmodule

bind crc_stream_engine crc_stream_engine_sva #(.DW(DW), .DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .go(go), .count(count), .work(work),
  .wr_en(wr_en), .waddr(waddr), .push(push), .pop(pop)
);

// File: tb/tb_crc_stream_engine.sv
`timescale 1ns/1ps
module tb_crc_stream_engine;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0]  waddr = 0, raddr = 0;
  logic [15:0] wdata = 0, rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  crc_stream_engine dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr),
                         .wdata(wdata), .raddr(raddr), .rdata(rdata));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input int lm1,
                                          input logic [15:0] t, input logic [15:0] word);
    int w = (lm1 < 8) ? 8 : 16;
    logic [15:0] m = 16'((32'd1 << (lm1 + 1)) - 1);
    for (int i = w - 1; i >= 0; i--) begin
      logic fb = c[lm1] ^ word[i];
      c = (c << 1) & m;
      if (fb) c = c ^ (t & m);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1; waddr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    raddr = a; #0.5; d = rdata;
  endtask

  task automatic push_checked(input logic [15:0] d);
    logic [15:0] s;
    forever begin
      @(negedge clk); #0.2;
      rd(2'd0, s);
      if (!s[5]) begin
        wr_en = 1; waddr = 2'd3; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
        break;
      end
    end
  endtask

  task automatic wait_empty(input string req, output int cyc);
    logic [15:0] s;
    cyc = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, s);
      if (s[6]) return;
      @(posedge clk); #1;
      cyc++;
    end
    chk(req, 16'h0, 16'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, exp, words[$];
    int cyc;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(2'd0, v); chk("R1 ctrl reset", v, 16'h0040);
    rd(2'd1, v); chk("R1 taps reset", v, 16'h0000);
    rd(2'd2, v); chk("R1 work reset", v, 16'h0000);
    rd(2'd3, v); chk("R2 data reads zero", v, 16'h0000);

    // R3 R4: 8-bit length, upper byte of each word must be ignored
    wr(2'd0, 16'h0007); wr(2'd1, 16'h0031); wr(2'd2, 16'h0000);
    exp = 0;
    foreach (words[i]) ;
    for (int i = 0; i < 3; i++) begin
      v = {8'hA5 ^ 8'(i), 8'h31 + 8'(i)};
      exp = ref_crc(exp, 7, 16'h31, {8'h00, v[7:0]});
      wr(2'd3, v);
    end
    wr(2'd0, 16'h0017); wait_empty("R6 drain", cyc);
    rd(2'd2, v); chk("R3 R4 8-bit crc", v, exp);
    wr(2'd0, 16'h0007);

    // R5 R7: eight 16-bit words, a ninth dropped, 64-cycle drain
    wr(2'd0, 16'h000F); wr(2'd1, 16'h1021); wr(2'd2, 16'hFFFF);
    exp = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      v = 16'h1357 * 16'(i + 1);
      exp = ref_crc(exp, 15, 16'h1021, v);
      wr(2'd3, v);
    end
    rd(2'd0, v); chk("R5 full flag", v & 16'h0060, 16'h0020);
    wr(2'd3, 16'hDEAD);
    @(negedge clk); #1; wr_en = 1; waddr = 2'd0; wdata = 16'h001F;
    @(posedge clk); #1; wr_en = 0;
    wait_empty("R7 drain", cyc);
    chk("R7 64 cycles for 128 bits", 16'(cyc), 16'd64);
    rd(2'd2, v); chk("R5 ninth word dropped", v, exp);

    // R8: accumulator locked while run set
    wr(2'd2, 16'h1234); rd(2'd2, v); chk("R8 write blocked while run", v, exp);
    wr(2'd0, 16'h000F); wr(2'd2, 16'h1234); rd(2'd2, v); chk("R8 write when idle", v, 16'h1234);

    // R9 R6: no shifting with run clear; push clears empty
    wr(2'd3, 16'hBEEF); wr(2'd3, 16'h0F0F);
    repeat (10) @(posedge clk); #1;
    rd(2'd2, v); chk("R9 work held idle", v, 16'h1234);
    rd(2'd0, v); chk("R6 empty cleared by push", v & 16'h0040, 16'h0000);
    exp = ref_crc(ref_crc(16'h1234, 15, 16'h1021, 16'hBEEF), 15, 16'h1021, 16'h0F0F);
    wr(2'd0, 16'h001F); wait_empty("R9 drain", cyc);
    rd(2'd2, v); chk("R9 queued words kept", v, exp);
    wr(2'd0, 16'h000F);

    // R8: split 12-bit message, save and restore partial result
    begin
      logic [15:0] part;
      wr(2'd0, 16'h000B); wr(2'd1, 16'h080F); wr(2'd2, 16'h0000);
      exp = 0;
      for (int i = 0; i < 4; i++) begin
        v = 16'hA1B2 + 16'(i * 77);
        exp = ref_crc(exp, 11, 16'h080F, v); wr(2'd3, v);
      end
      wr(2'd0, 16'h001B); wait_empty("R8 part A", cyc); wr(2'd0, 16'h000B);
      rd(2'd2, part);
      wr(2'd2, 16'h0ABC);
      wr(2'd2, part);
      for (int i = 0; i < 4; i++) begin
        v = 16'h5C3D ^ 16'(i * 901);
        exp = ref_crc(exp, 11, 16'h080F, v); wr(2'd3, v);
      end
      wr(2'd0, 16'h001B); wait_empty("R8 part B", cyc);
      rd(2'd2, v); chk("R8 resumed crc", v, exp);
      wr(2'd0, 16'h000B);
    end

    // R3: 5-bit length with zero-word finish
    wr(2'd0, 16'h0004); wr(2'd1, 16'h0005); wr(2'd2, 16'h001F);
    exp = ref_crc(ref_crc(16'h001F, 4, 16'h5, 16'h00C7), 4, 16'h5, 16'h0000);
    wr(2'd3, 16'h00C7); wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0014); wait_empty("R3 drain", cyc);
    rd(2'd2, v); chk("R3 5-bit crc", v, exp);
    wr(2'd0, 16'h0004);

    // R10: random streams pushed while the shifter drains
    for (int it = 0; it < 30; it++) begin
      int lm1 = 4 + int'($urandom_range(0, 11));
      logic [15:0] m = 16'((32'd1 << (lm1 + 1)) - 1);
      logic [15:0] tp = 16'($urandom) & m;
      logic [15:0] sd = 16'($urandom) & m;
      int n = int'($urandom_range(1, 20));
      wr(2'd0, 16'(lm1)); wr(2'd1, tp); wr(2'd2, sd);
      wr(2'd0, 16'(lm1) | 16'h0010);
      exp = sd;
      for (int k = 0; k < n; k++) begin
        v = 16'($urandom);
        exp = ref_crc(exp, lm1, tp, v);
        push_checked(v);
        repeat ($urandom_range(0, 2)) @(posedge clk);
      end
      wait_empty("R10 drain", cyc);
      rd(2'd2, v); chk("R10 streamed crc", v, exp);
      wr(2'd0, 16'(lm1));
    end

    finish_run();
  end
endmodule